// File: doc/BRIEF.md
# Machine-Cycle Clock Rate Controller

This block turns the oscillator clock of a small microcontroller core into machine-cycle timing. A machine cycle has four phases, C1 to C4. It lasts 4, 64 or 1024 oscillator clocks, chosen by a two-bit rate field that software writes. The two slow rates are power-saving modes. The block gives a one-hot phase vector, a one-clock tick at the start of each machine cycle, and an address-latch style strobe that is high during C1 and C2.

Software writes to the rate field are checked against a transition rule. A slow rate can only be reached from, and left to, the divide-by-4 rate. Any write that breaks the rule is dropped, and the field keeps its old value. A hardware switchback request forces a return to divide-by-4, and it wins over software. A rate change never cuts a phase short: the running rate changes only at the end of a machine cycle. The control pins are plain level signals. The block has no streaming interface, so it has no back-pressure.

Top module: `mcyc_clkgen`

## Requirements
- R1: While reset is asserted and in the first clock after it is released, the rate readback is 01 (divide-by-4), the phase vector is 0001 (bit 0 is C1, bit 3 is C4) and the tick output is high.
- R2: At rate code 01, ticks are 4 clocks apart and each phase lasts one clock.
- R3: At rate code 10, ticks are 64 clocks apart and each phase lasts 16 clocks.
- R4: At rate code 11, ticks are 1024 clocks apart and each phase lasts 256 clocks.
- R5: A write of code 00 is ignored, and the readback keeps its value.
- R6: A write that asks for a slow code (10 or 11) is accepted only when both the readback and the running rate are 01. In particular, a direct change between 10 and 11 is ignored. A write of 01, or of the value already held, is always allowed.
- R7: An accepted write shows on the readback one clock later. The running rate takes the new value at the first machine-cycle boundary at or after the write, so the cycle in progress completes at the old rate.
- R8: A one-clock switchback pulse while the readback is 10 or 11 sets the readback to 01 at the next machine-cycle boundary. From then on ticks are 4 clocks apart. At rate 01 the pulse has no effect.
- R9: A write in the same clock as an effective switchback pulse is ignored, and so is any write made while a switchback is pending.
- R10: The tick output is high for exactly one clock, at the start of C1. The strobe is high during C1 and C2, which is half of each machine cycle. Exactly one phase bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_we | input | 1 | Write strobe for the rate field |
| rate_wdata | input | 2 | Requested rate code (01 = /4, 10 = /64, 11 = /1024) |
| swb_req | input | 1 | Hardware switchback request |
| rate_rd | output | 2 | Current rate field readback |
| phase | output | 4 | One-hot machine-cycle phase, bit 0 = C1 |
| mc_tick | output | 1 | One-clock pulse at the start of each machine cycle |
| ale_stb | output | 1 | High during C1 and C2 |

## Verification
The readback is due on the clock after a write or switchback pulse is captured. The bench drives inputs one time unit after a falling edge and reads `rate_rd` at the next falling edge. A new rate takes effect only at a boundary, so the bench pushes the tick intervals it expects right after it sees a tick. The expected list is the remainder of the current cycle at the old rate, followed by cycles at the new rate. A monitor counts clocks and strobe-high clocks between ticks, and it compares each interval with the next expected value in the queue. Switchback results are read at a point still inside the pending cycle, then again after the boundary.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  typedef enum logic [1:0] {
    RATE_BAD   = 2'b00,
    RATE_D4    = 2'b01,
    RATE_D64   = 2'b10,
    RATE_D1024 = 2'b11
  } rate_e;

  localparam int unsigned PHASES = 4;
endpackage

// File: rtl/mcyc_rate_ctl.sv
module mcyc_rate_ctl
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  input  logic       swb_i,
  input  logic       boundary_i,
  output rate_e      field_o,
  output rate_e      active_o
);
  rate_e field_q, field_d, active_q, req;
  logic  swb_pend_q, swb_hit, swb_block, slow_ok, accept;

  assign req       = rate_e'(wdata_i);
  assign swb_hit   = swb_i && (field_q != RATE_D4);
  assign swb_block = swb_hit || swb_pend_q;
  assign slow_ok   = (field_q == RATE_D4) && (active_q == RATE_D4);
  assign accept    = we_i && !swb_block && (req != RATE_BAD) &&
                     ((req == RATE_D4) || (req == field_q) || slow_ok);

  always_comb begin
    field_d = field_q;
    if (boundary_i && swb_block) field_d = RATE_D4;
    else if (accept)             field_d = req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q    <= RATE_D4;
      active_q   <= RATE_D4;
      swb_pend_q <= 1'b0;
    end else begin
      field_q <= field_d;
      if (boundary_i) begin
        active_q   <= field_d;
        swb_pend_q <= 1'b0;
      end else if (swb_hit) begin
        swb_pend_q <= 1'b1;
      end
    end
  end

  assign field_o  = field_q;
  assign active_o = active_q;

  AST_FIELD_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    field_q != RATE_BAD); // R5
  AST_SLOW_VIA_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q != $past(field_q)) |-> (field_q == RATE_D4 || $past(field_q) == RATE_D4)); // R6
  AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> $past(boundary_i)); // R7
  AST_SWB_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && swb_pend_q) |=> (field_q == RATE_D4)); // R8
  AST_SWB_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_block && we_i) |=> (field_q == $past(field_q) || field_q == RATE_D4)); // R9
endmodule

// File: rtl/mcyc_prescaler.sv
module mcyc_prescaler
  import mcyc_pkg::*;
#(
  parameter int unsigned FAST_LEN = 1,
  parameter int unsigned MID_LEN  = 16,
  parameter int unsigned SLOW_LEN = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e active_i,
  output logic  step_o,
  output logic  first_o
);
  localparam int unsigned CNT_W = (SLOW_LEN > 1) ? $clog2(SLOW_LEN) : 1;

  logic [CNT_W-1:0] cnt_q, last_val;

  always_comb begin
    case (active_i)
      RATE_D64:   last_val = CNT_W'(MID_LEN - 1);
      RATE_D1024: last_val = CNT_W'(SLOW_LEN - 1);
      default:    last_val = CNT_W'(FAST_LEN - 1);
    endcase
  end

  assign step_o  = (cnt_q == last_val);
  assign first_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_val); // R7
endmodule

// File: rtl/mcyc_phase_seq.sv
module mcyc_phase_seq
  import mcyc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                first_i,
  output logic [PHASES-1:0]   phase_o,
  output logic                tick_o,
  output logic                strobe_o,
  output logic                boundary_o
);
  logic [1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ph_q <= 2'd0;
    else if (step_i) ph_q <= ph_q + 2'd1;
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_dec
    assign phase_o[g] = (ph_q == g[1:0]);
  end

  assign boundary_o = step_i && (ph_q == 2'd3);
  assign tick_o     = first_i && (ph_q == 2'd0);
  assign strobe_o   = !ph_q[1];

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_o) == 1); // R10
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R10
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (phase_o == {$past(phase_o[PHASES-2:0]), $past(phase_o[PHASES-1])})); // R2
endmodule

// File: rtl/mcyc_clkgen.sv
module mcyc_clkgen
  import mcyc_pkg::*;
#(
  parameter int unsigned FAST_DIV = 4,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned SLOW_DIV = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_we,
  input  logic [1:0] rate_wdata,
  input  logic       swb_req,
  output logic [1:0] rate_rd,
  output logic [3:0] phase,
  output logic       mc_tick,
  output logic       ale_stb
);
  localparam int unsigned FAST_LEN = FAST_DIV / PHASES;
  localparam int unsigned MID_LEN  = MID_DIV / PHASES;
  localparam int unsigned SLOW_LEN = SLOW_DIV / PHASES;

  rate_e field, active;
  logic  step, first, boundary;

  mcyc_rate_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (rate_we),
    .wdata_i    (rate_wdata),
    .swb_i      (swb_req),
    .boundary_i (boundary),
    .field_o    (field),
    .active_o   (active)
  );

  mcyc_prescaler #(
    .FAST_LEN (FAST_LEN),
    .MID_LEN  (MID_LEN),
    .SLOW_LEN (SLOW_LEN)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .step_o   (step),
    .first_o  (first)
  );

  mcyc_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .first_i    (first),
    .phase_o    (phase),
    .tick_o     (mc_tick),
    .strobe_o   (ale_stb),
    .boundary_o (boundary)
  );

  assign rate_rd = field;

  AST_TICK_AT_C1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_tick) |-> phase[0] && ale_stb); // R10
endmodule

// File: tb/mcyc_clkgen_tb.sv
module mcyc_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_we = 1'b0;
  logic [1:0] rate_wdata = 2'b00;
  logic       swb_req = 1'b0;
  logic [1:0] rate_rd;
  logic [3:0] phase;
  logic       mc_tick, ale_stb;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int clk_cnt = 0;
  int ale_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcyc_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .swb_req(swb_req), .rate_rd(rate_rd), .phase(phase),
    .mc_tick(mc_tick), .ale_stb(ale_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measure interval and strobe-high count between ticks
  always @(negedge clk) begin
    if (rst_n) begin
      if (mc_tick) begin
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check(clk_cnt == e, "R2/R3/R4 tick interval", clk_cnt, e);
          check(ale_cnt == e / 2, "R10 strobe length", ale_cnt, e / 2);
        end
        clk_cnt = 1;
        ale_cnt = ale_stb ? 1 : 0;
      end else begin
        clk_cnt++;
        if (ale_stb) ale_cnt++;
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!mc_tick);
    #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic push3(input int a, input int b, input int c);
    exp_q.push_back(a);
    if (b > 0) exp_q.push_back(b);
    if (c > 0) exp_q.push_back(c);
  endtask

  task automatic wr(input logic [1:0] v, input logic swb);
    rate_we = 1'b1;
    rate_wdata = v;
    swb_req = swb;
    @(negedge clk);
    #1;
    rate_we = 1'b0;
    swb_req = 1'b0;
  endtask

  task automatic pulse_swb();
    swb_req = 1'b1;
    @(negedge clk);
    #1;
    swb_req = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] e, input string req);
    check(rate_rd == e, req, rate_rd, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(rate_rd == 2'b01, "R1 reset readback", rate_rd, 1);
    check(phase == 4'b0001, "R1 reset phase", phase, 1);
    check(mc_tick == 1'b1, "R1 reset tick", mc_tick, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(mc_tick == 1'b1 && phase == 4'b0001, "R1 first cycle", {mc_tick, phase}, 5'b10001);

    // R2 divide-by-4, phase advances each clock
    wait_tick();
    push3(4, 4, 0);
    @(negedge clk); #1;
    check(phase == 4'b0010, "R2 phase C2 after one clock", phase, 2);
    wait_ticks(2);

    // R7 accepted write to /64: readback next clock, rate at boundary (R3)
    push3(4, 64, 64);
    wr(2'b10, 1'b0);
    chk_rd(2'b10, "R7 readback after write");
    wait_ticks(3);

    // R6 direct 10->11 ignored, R5 00 ignored
    push3(64, 64, 0);
    wr(2'b11, 1'b0);
    chk_rd(2'b10, "R6 direct slow to slow ignored");
    wr(2'b00, 1'b0);
    chk_rd(2'b10, "R5 code 00 ignored in slow mode");
    wait_ticks(2);

    // return to /4, then slow request before boundary rejected (R6)
    push3(64, 4, 0);
    wr(2'b01, 1'b0);
    chk_rd(2'b01, "R7 legal return to 01");
    wr(2'b11, 1'b0);
    chk_rd(2'b01, "R6 slow request while rate still slow");
    wait_ticks(2);

    // R4 divide-by-1024, pending 10 request rejected
    push3(4, 1024, 1024);
    wr(2'b11, 1'b0);
    chk_rd(2'b11, "R7 write 11 from 01");
    wr(2'b10, 1'b0);
    chk_rd(2'b11, "R6 11 to 10 ignored");
    wait_ticks(3);

    // R8/R9 switchback with simultaneous write in /1024
    push3(1024, 4, 4);
    wr(2'b01, 1'b1);
    chk_rd(2'b11, "R9 write beside switchback ignored");
    repeat (10) @(negedge clk);
    #1;
    chk_rd(2'b11, "R8 readback held until boundary");
    wait_ticks(3);
    chk_rd(2'b01, "R8 readback 01 after boundary");

    // R8 switchback at /4 has no effect; R5 00 at /4 ignored
    push3(4, 4, 0);
    pulse_swb();
    chk_rd(2'b01, "R8 switchback no effect at 01");
    wr(2'b00, 1'b0);
    chk_rd(2'b01, "R5 code 00 ignored at 01");
    wait_ticks(2);

    // R9 write while switchback pending in /64
    push3(4, 64, 0);
    wr(2'b10, 1'b0);
    chk_rd(2'b10, "R7 write 10");
    wait_ticks(2);
    push3(64, 4, 0);
    pulse_swb();
    wr(2'b01, 1'b0);
    chk_rd(2'b10, "R9 write while switchback pending ignored");
    wait_ticks(2);
    chk_rd(2'b01, "R8 switchback from 10");

    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin
      @(posedge clk);
      n++;
    end
    if (!done) check(1'b0, "watchdog", n, 0);
    else check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule